// File: doc/BRIEF.md
# Serial ADC Sample Link Receiver

This block takes sample frames from a remote eight-channel converter board. The frames arrive on two asynchronous serial lines. Line A carries channels 0 to 3 and line B carries channels 4 to 7. Each line has its own receive path, made of three parts:

- a synchronizer, followed by a short register delay chain;
- a framing state machine (the parent);
- a byte receiver (the child), which checks each byte's parity and stop bit.

A frame on one line is four packets, one per channel in ascending order. Each packet is three bytes: a header, then the sample's upper byte, then its lower byte. A fully good packet updates a 16-bit sample register and pulses that channel's update strobe. A fully good packet also sets that channel's bit in the valid bitmap. The byte receiver looks at a copy of the line that is delayed several cycles past the synchronized copy. The synchronized copy triggers the framing machine. Because of the delay, the byte receiver is already waiting for the start bit before that start bit reaches it, even though the start command takes cycles to pass from the parent to the child.

Corrupt bytes from both lines are counted in one shared saturating counter. A corrupt byte is one that fails parity or lacks its stop bit.

Top module: `sadc_link_rx`

## Requirements
- R1: Each serial line passes through two synchronizing flops. A falling edge on the synchronized line while that line's framer is idle starts a frame. The header byte whose start bit made that edge is itself received correctly.
- R2: A byte is one low start bit, eight data bits sent least significant bit first, one even-parity bit (the XOR of the data bits and the parity bit is 0) and one high stop bit. Each bit lasts CLKS_PER_BIT clocks and is sampled near its middle.
- R3: A frame holds four packets of three bytes each, in the order header, upper byte, lower byte. The sample value is {upper, lower} and the header contents are ignored. Packet k of line A belongs to channel k, and packet k of line B belongs to channel 4+k. sample_o[16*c +: 16] is channel c.
- R4: A sample register changes only when all three bytes of its packet pass parity. On that change, sample_upd_o[c] is high for exactly one cycle. A packet with any parity failure leaves the register unchanged.
- R5: Line A owns valid_o[3:0] and line B owns valid_o[7:4]. A frame start on one line clears that line's four bits and leaves the other four untouched.
- R6: valid_o[c] is set together with the update strobe of channel c. It stays set until the next frame start on its line.
- R7: Every byte that fails parity raises corrupt_cnt_o by one.
- R8: A byte whose stop bit samples low is counted as corrupt and ends the frame on that line. The packets that would have followed are not received. The framer then waits for a new falling edge.
- R9: corrupt_cnt_o saturates at its all-ones value and is cleared only by reset. Corrupt bytes completing on both lines in the same cycle add two.
- R10: After reset, every sample is 0, valid_o is 0, corrupt_cnt_o is 0 and no update strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_a_i | input | 1 | Serial line A, channels 0 to 3, idles high |
| ser_b_i | input | 1 | Serial line B, channels 4 to 7, idles high |
| sample_o | output | 128 | Eight 16-bit sample registers, channel c at bits 16*c+15 down to 16*c |
| sample_upd_o | output | 8 | One-cycle update strobe per channel |
| valid_o | output | 8 | Per-channel valid bitmap |
| corrupt_cnt_o | output | CNT_W | Saturating count of corrupt bytes (16 bits by default) |

## Verification
The two lines are driven in lockstep, bit for bit, so the corrupt-byte reports of both byte receivers land in the same clock cycle. This can increment the shared counter by two at once, and near saturation it can push the counter past its limit. The bench judges it against a model that adds each byte's contribution and clamps at all-ones, in a run where both lines carry parity errors until the counter pins. A frame start on one line can also fall in a cycle where the other line's framer is setting its own valid bits. A frame sent on line A alone shows that line B's half of the bitmap survives.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

    // Child receiver states
    typedef enum logic [1:0] {
        BR_IDLE,
        BR_WAIT_FOR_START_BIT,
        BR_RUN
    } br_state_e;

    // Parent framing states
    typedef enum logic {
        FR_IDLE,
        FR_ACTIVE
    } fr_state_e;

    // One received byte as reported by the child to the parent
    typedef struct packed {
        logic       done;
        logic [7:0] data;
        logic       par_err;
        logic       stop_err;
    } byte_res_t;

    // start + 8 data + parity + stop
    localparam int unsigned BIT_SLOTS    = 11;
    localparam int unsigned BYTES_PER_PK = 3;

endpackage

// File: rtl/sadc_line_sync.sv
module sadc_line_sync #(
    parameter int unsigned DLY_STAGES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic fall_o,
    output logic dly_o
);
    // two synchronizer flops followed by DLY_STAGES delay flops
    localparam int unsigned NS = 2 + DLY_STAGES;

    logic [NS-1:0] shf_d, shf_q;

    always_comb begin
        shf_d = {shf_q[NS-2:0], line_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shf_q <= '1;
        else        shf_q <= shf_d;
    end

    // shf_q[1] is the synchronized line, shf_q[2] its value one cycle earlier
    assign fall_o = shf_q[2] & ~shf_q[1];
    assign dly_o  = shf_q[NS-1];

endmodule

// File: rtl/sadc_byte_rx.sv
module sadc_byte_rx
    import sadc_pkg::*;
#(
    parameter int unsigned CLKS_PER_BIT = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start_i,
    input  logic      line_i,
    output byte_res_t res_o
);
    localparam int unsigned CW   = $clog2(CLKS_PER_BIT + 1);
    localparam int unsigned HALF = CLKS_PER_BIT / 2;
    localparam logic [CW-1:0] CNT_LAST  = CW'(CLKS_PER_BIT - 1);
    localparam logic [CW-1:0] CNT_ENTRY = CW'(CLKS_PER_BIT - HALF);
    localparam logic [3:0]    SLOT_LAST = 4'(BIT_SLOTS - 1);

    typedef struct packed {
        br_state_e  state;
        logic [CW-1:0] cnt;
        logic [3:0] slot;
        logic [8:0] shreg;
        logic       prev;
        byte_res_t  res;
    } br_t;

    br_t d, q;

    always_comb begin
        d          = q;
        d.prev     = line_i;
        d.res.done = 1'b0;
        unique case (q.state)
            BR_IDLE: begin
                if (start_i) d.state = BR_WAIT_FOR_START_BIT;
            end
            BR_WAIT_FOR_START_BIT: begin
                if (q.prev && !line_i) begin
                    d.state = BR_RUN;
                    d.cnt   = CNT_ENTRY;
                    d.slot  = '0;
                end
            end
            BR_RUN: begin
                if (q.cnt == CNT_LAST) begin
                    d.cnt = '0;
                    if (q.slot == '0) begin
                        // start bit must still be low at mid-bit
                        if (line_i) d.state = BR_WAIT_FOR_START_BIT;
                        else        d.slot  = 4'd1;
                    end else if (q.slot == SLOT_LAST) begin
                        d.res.done     = 1'b1;
                        d.res.data     = q.shreg[7:0];
                        d.res.par_err  = ^q.shreg;
                        d.res.stop_err = ~line_i;
                        d.state        = BR_IDLE;
                    end else begin
                        d.shreg = {line_i, q.shreg[8:1]};
                        d.slot  = q.slot + 4'd1;
                    end
                end else begin
                    d.cnt = q.cnt + CW'(1);
                end
            end
            default: d.state = BR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= BR_IDLE;
            q.prev  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign res_o = q.res;

endmodule

// File: rtl/sadc_frame_rx.sv
module sadc_frame_rx
    import sadc_pkg::*;
#(
    parameter int unsigned CLKS_PER_BIT = 16,
    parameter int unsigned CH_PER_LINE  = 4,
    parameter int unsigned SAMPLE_W     = 16
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            fall_i,
    input  logic                            line_dly_i,
    output logic [CH_PER_LINE*SAMPLE_W-1:0] sample_o,
    output logic [CH_PER_LINE-1:0]          upd_o,
    output logic [CH_PER_LINE-1:0]          valid_o,
    output logic                            corrupt_o
);
    localparam int unsigned PW = (CH_PER_LINE > 1) ? $clog2(CH_PER_LINE) : 1;
    localparam logic [PW-1:0] PKT_LAST  = PW'(CH_PER_LINE - 1);
    localparam logic [1:0]    BIDX_LAST = 2'(BYTES_PER_PK - 1);

    typedef struct packed {
        fr_state_e  state;
        logic       start;
        logic [1:0] bidx;
        logic [PW-1:0] pkt;
        logic       bad;
        logic [7:0] msb;
        logic [CH_PER_LINE-1:0] valid;
        logic [CH_PER_LINE-1:0] upd;
        logic [CH_PER_LINE-1:0][SAMPLE_W-1:0] smp;
    } fr_t;

    fr_t       d, q;
    byte_res_t res;

    sadc_byte_rx #(
        .CLKS_PER_BIT(CLKS_PER_BIT)
    ) u_byte (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(q.start),
        .line_i (line_dly_i),
        .res_o  (res)
    );

    always_comb begin
        d       = q;
        d.start = 1'b0;
        d.upd   = '0;
        unique case (q.state)
            FR_IDLE: begin
                if (fall_i) begin
                    d.state = FR_ACTIVE;
                    d.start = 1'b1;
                    d.bidx  = '0;
                    d.pkt   = '0;
                    d.bad   = 1'b0;
                    d.valid = '0;
                end
            end
            FR_ACTIVE: begin
                if (res.done) begin
                    if (res.stop_err) begin
                        d.state = FR_IDLE;
                    end else if (q.bidx == BIDX_LAST) begin
                        if (!(q.bad || res.par_err)) begin
                            d.smp[q.pkt]   = {q.msb, res.data};
                            d.valid[q.pkt] = 1'b1;
                            d.upd[q.pkt]   = 1'b1;
                        end
                        if (q.pkt == PKT_LAST) begin
                            d.state = FR_IDLE;
                        end else begin
                            d.pkt   = q.pkt + PW'(1);
                            d.bidx  = '0;
                            d.bad   = 1'b0;
                            d.start = 1'b1;
                        end
                    end else begin
                        d.bad = q.bad | res.par_err;
                        if (q.bidx == 2'd1) d.msb = res.data;
                        d.bidx  = q.bidx + 2'd1;
                        d.start = 1'b1;
                    end
                end
            end
            default: d.state = FR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= FR_IDLE;
        end else begin
            q <= d;
        end
    end

    assign sample_o  = q.smp;
    assign upd_o     = q.upd;
    assign valid_o   = q.valid;
    assign corrupt_o = res.done & (res.par_err | res.stop_err);

endmodule

// File: rtl/sadc_link_rx.sv
module sadc_link_rx #(
    parameter int unsigned CLKS_PER_BIT = 16,
    parameter int unsigned DLY_STAGES   = 4,
    parameter int unsigned CH_PER_LINE  = 4,
    parameter int unsigned CNT_W        = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ser_a_i,
    input  logic                    ser_b_i,
    output logic [2*CH_PER_LINE*16-1:0] sample_o,
    output logic [2*CH_PER_LINE-1:0]    sample_upd_o,
    output logic [2*CH_PER_LINE-1:0]    valid_o,
    output logic [CNT_W-1:0]            corrupt_cnt_o
);
    localparam int unsigned NUM_LINES = 2;
    localparam int unsigned SAMPLE_W  = 16;
    localparam int unsigned LINE_SW   = CH_PER_LINE * SAMPLE_W;
    localparam logic [CNT_W:0] CNT_MAX = {1'b0, {CNT_W{1'b1}}};

    logic [NUM_LINES-1:0] ser;
    logic [NUM_LINES-1:0] corrupt;

    assign ser = {ser_b_i, ser_a_i};

    for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
        logic fall, dly;

        sadc_line_sync #(
            .DLY_STAGES(DLY_STAGES)
        ) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .line_i(ser[l]),
            .fall_o(fall),
            .dly_o (dly)
        );

        sadc_frame_rx #(
            .CLKS_PER_BIT(CLKS_PER_BIT),
            .CH_PER_LINE (CH_PER_LINE),
            .SAMPLE_W    (SAMPLE_W)
        ) u_frame (
            .clk       (clk),
            .rst_n     (rst_n),
            .fall_i    (fall),
            .line_dly_i(dly),
            .sample_o  (sample_o[l*LINE_SW +: LINE_SW]),
            .upd_o     (sample_upd_o[l*CH_PER_LINE +: CH_PER_LINE]),
            .valid_o   (valid_o[l*CH_PER_LINE +: CH_PER_LINE]),
            .corrupt_o (corrupt[l])
        );
    end

    // Shared saturating corrupt counter
    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W:0]   cnt_sum;

    always_comb begin
        cnt_sum = {1'b0, cnt_q};
        for (int l = 0; l < NUM_LINES; l++) begin
            cnt_sum = cnt_sum + (CNT_W+1)'(corrupt[l]);
        end
        cnt_d = (cnt_sum > CNT_MAX) ? CNT_MAX[CNT_W-1:0] : cnt_sum[CNT_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign corrupt_cnt_o = cnt_q;

endmodule

// File: rtl/sadc_link_rx_chk.sv
module sadc_link_rx_chk #(
    parameter int unsigned CH_PER_LINE = 4,
    parameter int unsigned CNT_W       = 16
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [2*CH_PER_LINE*16-1:0] sample_o,
    input logic [2*CH_PER_LINE-1:0]    sample_upd_o,
    input logic [2*CH_PER_LINE-1:0]    valid_o,
    input logic [CNT_W-1:0]            corrupt_cnt_o
);
    localparam int unsigned NUM_CH = 2 * CH_PER_LINE;

    AST_UPD_IMPLIES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_upd_o & ~valid_o) == '0); // R6

    AST_CNT_NO_DECREASE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> corrupt_cnt_o >= $past(corrupt_cnt_o)); // R9

    AST_CNT_STEP_MAX_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> {1'b0, corrupt_cnt_o} <= {1'b0, $past(corrupt_cnt_o)} + (CNT_W+1)'(2)); // R9

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam int unsigned LB = (c / CH_PER_LINE) * CH_PER_LINE;

        AST_SAMPLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(sample_o[c*16 +: 16]) |-> sample_upd_o[c]); // R4

        AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(valid_o[c]) |-> sample_upd_o[c]); // R6

        AST_NIBBLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(valid_o[c]) |-> valid_o[LB +: CH_PER_LINE] == '0); // R5

        AST_UPD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
            sample_upd_o[c] |=> !sample_upd_o[c]); // R4
    end

endmodule

bind sadc_link_rx sadc_link_rx_chk #(
    .CH_PER_LINE(CH_PER_LINE),
    .CNT_W      (CNT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sample_o     (sample_o),
    .sample_upd_o (sample_upd_o),
    .valid_o      (valid_o),
    .corrupt_cnt_o(corrupt_cnt_o)
);

// File: tb/tb_sadc_link_rx.sv
module tb_sadc_link_rx;
    localparam int CLK_P = 10;
    localparam int CPB   = 16;
    localparam int CW    = 5;
    localparam int MAXC  = (1 << CW) - 1;
    localparam int NB    = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_a = 1'b1, ser_b = 1'b1;
    logic [127:0]  sample_o;
    logic [7:0]    sample_upd_o, valid_o;
    logic [CW-1:0] corrupt_cnt_o;

    sadc_link_rx #(.CLKS_PER_BIT(CPB), .DLY_STAGES(4), .CH_PER_LINE(4), .CNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .ser_a_i(ser_a), .ser_b_i(ser_b),
        .sample_o(sample_o), .sample_upd_o(sample_upd_o), .valid_o(valid_o),
        .corrupt_cnt_o(corrupt_cnt_o));

    always #(CLK_P/2) clk = ~clk;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    logic [7:0] fdat [2][NB];
    bit fpar [2][NB], fstop [2][NB], fact [2][NB];

    logic [15:0] exp_smp [8];
    logic [7:0]  exp_valid;
    int          exp_cnt;
    int          exp_upd [8];
    int          seen_upd [8];

    always @(posedge clk) begin
        if (rst_n) for (int c = 0; c < 8; c++) if (sample_upd_o[c]) seen_upd[c]++;
    end

    task automatic check(string req, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int sat_add(int v);
        return (v + 1 > MAXC) ? MAXC : v + 1;
    endfunction

    // Expected effect of one frame on one line (R3..R9)
    task automatic model_line(int l);
        bit bad;
        if (!fact[l][0]) return;
        exp_valid[l*4 +: 4] = 4'h0;
        for (int p = 0; p < 4; p++) begin
            bad = 0;
            for (int b = 0; b < 3; b++) begin
                int i = p*3 + b;
                if (!fact[l][i]) return;
                if (fpar[l][i] || fstop[l][i]) exp_cnt = sat_add(exp_cnt);
                if (fstop[l][i]) return;
                bad |= fpar[l][i];
                if (b == 2 && !bad) begin
                    exp_smp[l*4+p] = {fdat[l][i-1], fdat[l][i]};
                    exp_valid[l*4+p] = 1'b1;
                    exp_upd[l*4+p]++;
                end
            end
        end
    endtask

    function automatic logic line_bit(int l, int i, int pos);
        if (!fact[l][i]) return 1'b1;
        if (pos == 0) return 1'b0;
        if (pos <= 8) return fdat[l][i][pos-1];
        if (pos == 9) return (^fdat[l][i]) ^ fpar[l][i];
        return ~fstop[l][i];
    endfunction

    // Drives both lines in lockstep; optional valid check after byte chk_at
    task automatic send_frame(int chk_at, logic [7:0] chk_exp);
        for (int i = 0; i < NB; i++) begin
            for (int pos = 0; pos < 11; pos++) begin
                ser_a = line_bit(0, i, pos);
                ser_b = line_bit(1, i, pos);
                repeat (CPB) @(negedge clk);
            end
            ser_a = 1'b1; ser_b = 1'b1;
            if (i == chk_at) check("R5 valid after first byte", valid_o, chk_exp);
        end
        ser_a = 1'b1; ser_b = 1'b1;
        repeat (6*CPB) @(negedge clk);
        model_line(0);
        model_line(1);
    endtask

    task automatic check_all(string tag);
        for (int c = 0; c < 8; c++) begin
            check({"R3 R4 sample ", tag}, sample_o[c*16 +: 16], exp_smp[c]);
            check({"R4 update count ", tag}, seen_upd[c], exp_upd[c]);
        end
        check({"R6 valid ", tag}, valid_o, exp_valid);
        check({"R7 R9 corrupt count ", tag}, corrupt_cnt_o, exp_cnt);
    endtask

    task automatic fill(int l, bit act, int par_mod, int stop_mod, bit all_par_bad);
        bit alive = act;
        for (int i = 0; i < NB; i++) begin
            fdat[l][i] = 8'($urandom);
            fpar[l][i] = all_par_bad ? 1'b1 : (par_mod > 0 && ($urandom % par_mod) == 0);
            fstop[l][i] = alive && stop_mod > 0 && ($urandom % stop_mod) == 0;
            fact[l][i] = alive;
            if (fstop[l][i]) alive = 0;
        end
    endtask

    initial begin
        #(CLK_P * 190000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5ADC_0017));
        for (int c = 0; c < 8; c++) begin exp_smp[c] = '0; exp_upd[c] = 0; seen_upd[c] = 0; end
        exp_valid = '0; exp_cnt = 0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        // R10: reset state
        check("R10 samples zero", sample_o == '0, 1);
        check("R10 valid zero", valid_o, 0);
        check("R10 counter zero", corrupt_cnt_o, 0);
        check("R10 no strobe", sample_upd_o, 0);

        // R1 R2 R3: clean frame on both lines, first header from the start edge
        fill(0, 1, 0, 0, 0); fill(1, 1, 0, 0, 0);
        send_frame(-1, 0);
        check_all("clean");

        // R5: line A alone; B half of bitmap kept
        fill(0, 1, 0, 0, 0); fill(1, 0, 0, 0, 0);
        send_frame(0, 8'hF0);
        check_all("line A only");

        // R8: stop error on the header of line A, line B good
        fill(0, 1, 0, 0, 0); fill(1, 1, 0, 0, 0);
        fstop[0][0] = 1;
        for (int i = 1; i < NB; i++) fact[0][i] = 0;
        send_frame(-1, 0);
        check_all("stop error");

        // R7: parity error on a lower byte only of channel 5
        fill(0, 1, 0, 0, 0); fill(1, 1, 0, 0, 0);
        fpar[1][5] = 1;
        send_frame(-1, 0);
        check_all("single parity");

        // Random mix of parity errors, stop errors and idle lines
        for (int f = 0; f < 10; f++) begin
            fill(0, ($urandom % 8) != 0, 6, 25, 0);
            fill(1, ($urandom % 8) != 0, 6, 25, 0);
            send_frame(-1, 0);
            check_all("random");
        end

        // R9: both lines bad in lockstep until saturated
        for (int f = 0; f < 2; f++) begin
            fill(0, 1, 0, 0, 1); fill(1, 1, 0, 0, 1);
            send_frame(-1, 0);
            check_all("saturate");
        end
        check("R9 pinned at max", corrupt_cnt_o, MAXC);

        // R9: reset clears counter
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R9 R10 counter cleared by reset", corrupt_cnt_o, 0);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule